// File: doc/BRIEF.md
# Change-of-State and Edge Interrupt Controller

This block watches a bank of asynchronous digital input lines and raises one shared, level-sensitive interrupt request. It has two alternative ways of generating that request. In change-of-state mode, a transition in either direction on any input selected by a mask register latches a pending flag. In channel mode, a low-to-high transition on input 0 or input 1 latches a separate pending flag for each of those inputs, and each input has its own enable. Every input first passes through a synchronizer chain and then an edge detector. Edge detection is held off after reset until the previous-sample register holds real input data.

Software reaches the block through a small register port with two offsets. The control word holds three enable bits that can be read back, together with three write-1-to-clear bits for the pending flags. The second offset holds the change-of-state input mask. A four-state mode machine is driven by the enable bits and decides which source group may set pending flags. Its states are `MODE_IDLE` (nothing armed), `MODE_COS` (only change-of-state enabled), `MODE_CHAN` (only channel sources enabled) and `MODE_BOTH` (both requested). In `MODE_BOTH` only the channel sources are armed. The machine re-evaluates on every clock, so a state is left as soon as the enables change. It can move between any two states: IDLE to COS, IDLE to CHAN, COS to BOTH, CHAN to BOTH, BOTH back to COS, CHAN or IDLE, and so on. The new state takes effect one clock after the control write.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset, `irq` is 0, all enables, pending flags and mask bits read as 0.
- R2: The control word is at offset 0x08. Bits 10, 9 and 8 are the channel-1, channel-0 and change-of-state enables and read back as written. Bits 2, 1 and 0 read the channel-1, channel-0 and change-of-state pending flags. The mask is at offset 0x0C in bits NUM_IN-1:0. Any other offset reads 0, and writes to it change nothing.
- R3: An input change made just after one rising clock edge is latched as pending on the third rising edge. No event is latched for input levels present when reset is released.
- R4: In change-of-state mode, a rise or a fall on any input whose mask bit is 1 sets the change-of-state pending flag. Inputs whose mask bit is 0 do not set it.
- R5: In channel mode, a rising edge on input 0 (input 1) sets the channel-0 (channel-1) pending flag if that channel's enable is 1. Falling edges set nothing.
- R6: Writing 1 to a clear bit (bits 2:0 of the control word) drops that pending flag. Writing 0 there leaves it unchanged.
- R7: A pending flag stays set until it is cleared. Further events of that source do not change it.
- R8: When a clear and a new qualifying event of the same source fall in the same cycle, the flag remains set.
- R9: With change-of-state and any channel enabled together, change-of-state events set nothing, while channel events still set their flags.
- R10: `irq` is the OR of every pending flag whose enable bit is 1. Clearing an enable removes that source from `irq`, but its pending flag is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | NUM_IN | Asynchronous digital input lines |
| reg_addr | input | ADDR_W | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational readback of the addressed register |
| irq | output | 1 | Shared interrupt request |

## Verification
A fault in the mode machine or in the enable register is visible at `irq` and in the pending bits of the control readback. The pending bits show it three edges after the input change that ought (or ought not) to set them. An error in the synchronizer's warm-up counter appears as a spurious pending bit a few cycles after reset. A clear or priority error in the pending bank is visible on the readback in the cycle right after the write strobe. Because the pending flags are sticky, any wrongly set flag stays in view until software clears it.

// File: rtl/cos_irq_pkg.sv
package cos_irq_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE,
        MODE_COS,
        MODE_CHAN,
        MODE_BOTH
    } irq_mode_e;

    localparam int NUM_SRC = 3;
    localparam int SRC_COS = 0;
    localparam int SRC_CH0 = 1;
    localparam int SRC_CH1 = 2;

endpackage

// File: rtl/cos_irq_sync.sv
module cos_irq_sync #(
    parameter int NUM_IN      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] din,
    output logic [NUM_IN-1:0] toggle,
    output logic [NUM_IN-1:0] rise
);

    localparam int CNT_W = $clog2(SYNC_STAGES + 2);
    localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(SYNC_STAGES + 1);

    logic [NUM_IN-1:0] stage_q [SYNC_STAGES];
    logic [NUM_IN-1:0] prev_q;
    logic [CNT_W-1:0]  warm_q;
    logic              armed;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            warm_q <= '0;
        end else begin
            prev_q <= stage_q[SYNC_STAGES-1];
            if (warm_q != WARM_LAST) warm_q <= warm_q + 1'b1;
        end
    end

    assign armed  = (warm_q == WARM_LAST);
    assign toggle = armed ? (stage_q[SYNC_STAGES-1] ^ prev_q) : '0;
    assign rise   = armed ? (stage_q[SYNC_STAGES-1] & ~prev_q) : '0;

endmodule

// File: rtl/cos_irq_mode.sv
module cos_irq_mode
    import cos_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic want_cos,
    input  logic want_chan,
    output logic cos_arm,
    output logic chan_arm
);

    irq_mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case ({want_cos, want_chan})
            2'b00:   state_d = MODE_IDLE;
            2'b10:   state_d = MODE_COS;
            2'b01:   state_d = MODE_CHAN;
            default: state_d = MODE_BOTH;
        endcase
    end

    always_comb begin
        unique case (state_q)
            MODE_IDLE: begin cos_arm = 1'b0; chan_arm = 1'b0; end
            MODE_COS:  begin cos_arm = 1'b1; chan_arm = 1'b0; end
            MODE_CHAN: begin cos_arm = 1'b0; chan_arm = 1'b1; end
            MODE_BOTH: begin cos_arm = 1'b0; chan_arm = 1'b1; end
            default:   begin cos_arm = 1'b0; chan_arm = 1'b0; end
        endcase
    end

endmodule

// File: rtl/cos_irq_pend.sv
module cos_irq_pend #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] pend
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pend[i] <= 1'b0;
            else if (set[i]) pend[i] <= 1'b1;
            else if (clr[i]) pend[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
    import cos_irq_pkg::*;
#(
    parameter int          NUM_IN      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 16,
    parameter logic [7:0]  CTRL_OFS    = 8'h08,
    parameter logic [7:0]  MASK_OFS    = 8'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] din,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam int CLR_LSB = 0;
    localparam int EN_LSB  = 8;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_IN-1:0]  mask_q;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] set;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_IN-1:0]  toggle;
    logic [NUM_IN-1:0]  rise;
    logic               ctrl_wr;
    logic               mask_wr;
    logic               cos_arm;
    logic               chan_arm;

    assign ctrl_wr = reg_wr && (reg_addr == CTRL_A);
    assign mask_wr = reg_wr && (reg_addr == MASK_A);
    assign clr     = ctrl_wr ? reg_wdata[CLR_LSB +: NUM_SRC] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
        end else begin
            if (ctrl_wr) en_q   <= reg_wdata[EN_LSB +: NUM_SRC];
            if (mask_wr) mask_q <= reg_wdata[NUM_IN-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_A) begin
            reg_rdata[EN_LSB +: NUM_SRC]  = en_q;
            reg_rdata[CLR_LSB +: NUM_SRC] = pend;
        end else if (reg_addr == MASK_A) begin
            reg_rdata[NUM_IN-1:0] = mask_q;
        end
    end

    cos_irq_sync #(
        .NUM_IN     (NUM_IN),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .toggle(toggle),
        .rise  (rise)
    );

    cos_irq_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .want_cos (en_q[SRC_COS]),
        .want_chan(en_q[SRC_CH0] | en_q[SRC_CH1]),
        .cos_arm  (cos_arm),
        .chan_arm (chan_arm)
    );

    assign set[SRC_COS] = cos_arm && ((toggle & mask_q) != '0);
    assign set[SRC_CH0] = chan_arm && en_q[SRC_CH0] && rise[0];
    assign set[SRC_CH1] = chan_arm && en_q[SRC_CH1] && rise[1];

    cos_irq_pend #(
        .NSRC(NUM_SRC)
    ) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (set),
        .clr  (clr),
        .pend (pend)
    );

    assign irq = |(pend & en_q);

endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       ctrl_wr,
    input logic       cos_arm,
    input logic       chan_arm,
    input logic [2:0] en,
    input logic [2:0] pend,
    input logic [2:0] set,
    input logic [2:0] clr
);

    AST_ONE_GROUP_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !(cos_arm && chan_arm)); // R9

    AST_COS_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        !cos_arm |-> !set[0]); // R9

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~set) != 3'b000) |=> ((pend & $past(clr & ~set)) == 3'b000)); // R6

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~clr) != 3'b000) |=> ((pend & $past(pend & ~clr)) == $past(pend & ~clr))); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set != 3'b000) |=> ((pend & $past(set)) == $past(set))); // R8

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(en)); // R2

    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (en == 3'b000) |-> !irq); // R10

endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .ctrl_wr (ctrl_wr),
    .cos_arm (cos_arm),
    .chan_arm(chan_arm),
    .en      (en_q),
    .pend    (pend),
    .set     (set),
    .clr     (clr)
);

// File: tb/cos_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cos_irq_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  din = 8'hA5;
    logic [7:0]  reg_addr = 8'h00;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'h0000;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cos_irq_ctrl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .reg_addr (reg_addr),
        .reg_wr   (reg_wr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq      (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 16'h0000;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic flip(input int idx);
        @(negedge clk);
        din[idx] = ~din[idx];
        settle();
    endtask

    task automatic chk_pend(input string req, input logic [2:0] exp);
        logic [15:0] d;
        rd(8'h08, d);
        chk(req, {29'd0, d[2:0]}, {29'd0, exp});
    endtask

    task automatic t_reset();
        logic [15:0] d;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        rd(8'h08, d);
        chk("R1 ctrl after reset", {16'd0, d}, 32'h0);
        rd(8'h0C, d);
        chk("R1 mask after reset", {16'd0, d}, 32'h0);
        wr(8'h0C, 16'h00FF);
        wr(8'h08, 16'h0100);
        settle();
        chk_pend("R3 no event from levels at reset release", 3'b000);
        wr(8'h08, 16'h0001);
        wr(8'h0C, 16'h0000);
    endtask

    task automatic t_regs();
        logic [15:0] d;
        wr(8'h0C, 16'h000F);
        wr(8'h08, 16'h0100);
        rd(8'h0C, d);
        chk("R2 mask readback", {16'd0, d}, 32'h000F);
        rd(8'h08, d);
        chk("R2 ctrl readback", {16'd0, d}, 32'h0100);
        wr(8'h04, 16'hFFFF);
        rd(8'h0C, d);
        chk("R2 stray write leaves mask", {16'd0, d}, 32'h000F);
        rd(8'h08, d);
        chk("R2 stray write leaves ctrl", {16'd0, d}, 32'h0100);
        rd(8'h04, d);
        chk("R2 unmapped offset reads zero", {16'd0, d}, 32'h0);
    endtask

    task automatic t_cos();
        flip(7);
        chk_pend("R4 unmasked input ignored", 3'b000);
        chk("R4 irq quiet on unmasked", {31'd0, irq}, 32'd0);
        @(negedge clk); din[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R3 not yet pending after two edges", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R3 pending on third edge", {31'd0, irq}, 32'd1);
        chk_pend("R4 rising sets cos flag", 3'b001);
        wr(8'h08, 16'h0101);
        chk_pend("R6 write one clears", 3'b000);
        chk("R6 irq drops on clear", {31'd0, irq}, 32'd0);
        flip(1);
        chk_pend("R4 falling sets cos flag", 3'b001);
        wr(8'h08, 16'h0100);
        chk_pend("R6 write zero keeps flag", 3'b001);
        flip(2);
        chk_pend("R7 repeat event keeps flag", 3'b001);
        chk("R7 irq held", {31'd0, irq}, 32'd1);
        wr(8'h08, 16'h0101);
        chk_pend("R6 cleared again", 3'b000);
    endtask

    task automatic t_chan();
        wr(8'h08, 16'h0607);
        settle();
        flip(0);
        chk_pend("R5 falling edge ignored", 3'b000);
        flip(0);
        chk_pend("R5 rising input 0 sets ch0", 3'b010);
        chk("R10 irq from ch0", {31'd0, irq}, 32'd1);
        flip(1);
        chk_pend("R5 rising input 1 sets ch1", 3'b110);
        wr(8'h08, 16'h0606);
        chk_pend("R6 both channel flags cleared", 3'b000);
    endtask

    task automatic t_irq_en();
        flip(0);
        flip(0);
        chk_pend("R10 ch0 pending before disable", 3'b010);
        wr(8'h08, 16'h0400);
        chk("R10 irq drops with enable off", {31'd0, irq}, 32'd0);
        chk_pend("R10 pending kept when disabled", 3'b010);
        wr(8'h08, 16'h0600);
        chk("R10 irq back with enable on", {31'd0, irq}, 32'd1);
        wr(8'h08, 16'h0602);
        chk_pend("R6 ch0 cleared", 3'b000);
    endtask

    task automatic t_set_wins();
        flip(0);
        flip(0);
        flip(0);
        chk_pend("R8 flag set before race", 3'b010);
        @(negedge clk); din[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_addr = 8'h08; reg_wdata = 16'h0602; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = 16'h0000;
        chk_pend("R8 event beats clear", 3'b010);
        wr(8'h08, 16'h0602);
        chk_pend("R8 later clear works", 3'b000);
    endtask

    task automatic t_conflict();
        wr(8'h08, 16'h0707);
        settle();
        flip(2);
        chk_pend("R9 cos ignored with both modes", 3'b000);
        flip(3);
        chk_pend("R9 cos still ignored", 3'b000);
        flip(0);
        flip(0);
        chk_pend("R9 channel still works", 3'b010);
        wr(8'h08, 16'h0007);
        chk_pend("R6 all cleared", 3'b000);
        chk("R10 irq low at end", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regs();
        t_cos();
        t_chan();
        t_irq_en();
        t_set_wins();
        t_conflict();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule